// File: doc/BRIEF.md
# SPI Slave Shift Engine with Underflow and Deselect Detection

This block is the bit-level engine of an SPI slave. It runs on a fast system clock and oversamples the bus lines SCLK, MOSI and the select input. Each line passes through a two-flop synchronizer and an optional three-sample majority filter. Clock and select edges are then found inside the system clock domain. In each frame the engine exchanges one element in each direction. The element to send is taken from the head of a first-word-fall-through TX FIFO, and each received element is pushed to an RX FIFO.

The external master sets the bit rate. Writing the TX FIFO never starts a transfer by itself. An element moves only when the master drives clock edges while select is active. The engine commits to an element on that element's first leading clock edge: it pops the TX FIFO at that edge, or it records an underflow when the FIFO is empty. Until that edge, MISO shows the first bit of the FIFO head. This gives CPHA 0 its first bit without popping data that the master may never clock out. Two sticky flags are kept: one for TX underflow and one for a deselect in the middle of an element. They clear together on a clear pulse.

For correct operation, each SCLK half period must last at least 6 system clock cycles when the filter is enabled and at least 5 when it is bypassed. This covers the synchronizer, the filter, edge detection and the MISO update that follows.

Top module: `spi_slave_core`

## Requirements
- R1: Loading TX data starts no transfer. `tx_pop_o` pulses only on a leading SCLK edge while select is active, and SCLK edges while select is inactive are ignored. While select is inactive, `miso_oe_o` is 0.
- R2: The exchange is full duplex. Each element completed by the master produces exactly one `rx_push_o` pulse, with the received bits in `rx_data_o`.
- R3: On the first leading edge of an element, if `tx_valid_i` is 0, `underflow_o` becomes 1 and stays 1. MISO carries all ones for that element, and the received element is still pushed.
- R4: If select goes inactive after an element's first leading edge but before its last sampling edge, `slave_err_o` becomes 1 and stays 1. The partial element is not pushed.
- R5: The SCLK idle level equals `cpol_i`; a leading edge leaves the idle level and a trailing edge returns to it. With `cpha_i`=0, MOSI is sampled on leading edges, MISO changes on trailing edges, and the first bit is on MISO before the first leading edge. With `cpha_i`=1, MISO changes on leading edges and MOSI is sampled on trailing edges.
- R6: `width_i` selects the element width from 4 to 16 bits. TX bits at or above the width are never sent, and RX bits at or above the width read as 0.
- R7: With `msb_first_i`=1, bit width-1 is sent and received first. With `msb_first_i`=0, bit 0 is first.
- R8: With `ss_pol_i`=1, a high level on `ss_i` selects the slave. With `ss_pol_i`=0, a low level selects it.
- R9: With `filter_en_i`=1, each synchronized input is replaced by the majority of its last three samples, so a pulse one system clock wide on SCLK or MOSI has no effect.
- R10: `flag_clr_i` clears both sticky flags. A set request in the same cycle wins, and without a clear both flags hold their value.
- R11: After reset, `miso_o`=1, `miso_oe_o`=0, `tx_pop_o`=0, `rx_push_o`=0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| msb_first_i | input | 1 | 1: MSB first; 0: LSB first |
| width_i | input | CW (5) | Element width in bits, 4 to 16 |
| ss_pol_i | input | 1 | Active level of select |
| filter_en_i | input | 1 | Enable the three-sample majority filter |
| sclk_i | input | 1 | Bus clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_i | input | 1 | Select from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | MISO drive enable, high while selected |
| tx_valid_i | input | 1 | TX FIFO head is valid |
| tx_data_i | input | MAX_W | TX FIFO head element |
| tx_pop_o | output | 1 | Pop the TX FIFO head |
| rx_push_o | output | 1 | Push `rx_data_o` into the RX FIFO |
| rx_data_o | output | MAX_W | Received element |
| flag_clr_i | input | 1 | Clear both sticky flags |
| underflow_o | output | 1 | Sticky TX underflow |
| slave_err_o | output | 1 | Sticky deselect-mid-element error |

## Verification
The bench builds the block with the default parameters, MAX_W of 16 and two synchronizer stages. This leaves the full 4-to-16 bit width range selectable at run time. The bench steps `width_i` through 4, 6, 8, 12 and 16 and covers all four SCLK modes, both bit orders and both select polarities. It runs back-to-back elements inside one select window, a width-6 word with its upper bits set, an empty FIFO, a deselect after three bits, and single-cycle glitches with the filter on.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  localparam int unsigned MIN_W   = 4;
  localparam int unsigned LN_SCLK = 0;
  localparam int unsigned LN_MOSI = 1;
  localparam int unsigned LN_SS   = 2;
  localparam int unsigned N_LINES = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/spi_slv_cond.sv
module spi_slv_cond
  import spi_slv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filter_en_i,
  input  logic line_i,
  output logic lvl_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[0], sync_q[SYNC_STAGES-1]};
    end
  end

  // majority of current and two previous synced samples
  assign lvl_o = filter_en_i ? maj3(sync_q[SYNC_STAGES-1], hist_q[0], hist_q[1])
                             : sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/spi_slv_flags.sv
module spi_slv_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unf_set_i,
  input  logic err_set_i,
  input  logic clr_i,
  output logic underflow_o,
  output logic slave_err_o
);
  logic unf_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (unf_set_i)  unf_q <= 1'b1;
      else if (clr_i) unf_q <= 1'b0;
      if (err_set_i)  err_q <= 1'b1;
      else if (clr_i) err_q <= 1'b0;
    end
  end

  assign underflow_o = unf_q;
  assign slave_err_o = err_q;

  p_unf_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(unf_q) && !$past(clr_i)) |-> unf_q);
  p_err_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_q) && !$past(clr_i)) |-> err_q);
endmodule

// File: rtl/spi_slv_frame.sv
module spi_slv_frame
  import spi_slv_pkg::*;
#(
  parameter int unsigned MAX_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(MAX_W + 1),
  localparam int unsigned IW = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             msb_first_i,
  input  logic [CW-1:0]    width_i,
  input  logic             ss_pol_i,
  input  logic             sclk_lvl_i,
  input  logic             mosi_lvl_i,
  input  logic             ss_lvl_i,
  input  logic             tx_valid_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             tx_pop_o,
  output logic             miso_o,
  output logic             miso_oe_o,
  output logic             rx_push_o,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             unf_set_o,
  output logic             err_set_o
);
  localparam int unsigned PRIME = SYNC_STAGES + 4;

  logic [3:0]       prime_q;
  logic             armed;
  logic             sclk_q, ss_q;
  logic             sel_q, loaded_q;
  logic [CW-1:0]    tx_cnt_q, rx_cnt_q, eff_w;
  logic [MAX_W-1:0] tx_word_q, rx_word_q, rx_data_q;
  logic             rx_push_q;
  logic [IW-1:0]    tx_idx, rx_idx, first_idx;
  logic             sclk_chg, ss_chg, lead, trail, act_on, act_off;
  logic             lead_ev, trail_ev, start, samp, shift, last;

  always_comb begin
    if (width_i < CW'(MIN_W))      eff_w = CW'(MIN_W);
    else if (width_i > CW'(MAX_W)) eff_w = CW'(MAX_W);
    else                           eff_w = width_i;
  end

  assign armed    = (prime_q == 4'(PRIME));
  assign sclk_chg = armed & (sclk_lvl_i ^ sclk_q);
  assign ss_chg   = armed & (ss_lvl_i ^ ss_q);
  assign lead     = sclk_chg & (sclk_lvl_i != cpol_i);
  assign trail    = sclk_chg & (sclk_lvl_i == cpol_i);
  assign act_on   = ss_chg & (ss_lvl_i == ss_pol_i);
  assign act_off  = ss_chg & (ss_lvl_i != ss_pol_i);

  assign lead_ev  = sel_q & ~act_off & lead;
  assign trail_ev = sel_q & ~act_off & trail;
  assign start    = lead_ev & ~loaded_q;
  assign samp     = cpha_i ? (trail_ev & loaded_q) : lead_ev;
  assign shift    = loaded_q & (cpha_i ? lead_ev : trail_ev);
  assign last     = samp & (rx_cnt_q == eff_w - CW'(1));

  assign tx_idx    = msb_first_i ? IW'(eff_w - CW'(1) - tx_cnt_q) : IW'(tx_cnt_q);
  assign rx_idx    = msb_first_i ? IW'(eff_w - CW'(1) - rx_cnt_q) : IW'(rx_cnt_q);
  assign first_idx = msb_first_i ? IW'(eff_w - CW'(1)) : '0;

  // before the element commits, present the FIFO head (or filler) without popping
  always_comb begin
    if (!sel_q)        miso_o = 1'b1;
    else if (loaded_q) miso_o = tx_word_q[tx_idx];
    else if (tx_valid_i) miso_o = tx_data_i[first_idx];
    else               miso_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prime_q   <= '0;
      sclk_q    <= 1'b0;
      ss_q      <= 1'b0;
      sel_q     <= 1'b0;
      loaded_q  <= 1'b0;
      tx_cnt_q  <= '0;
      rx_cnt_q  <= '0;
      tx_word_q <= '1;
      rx_word_q <= '0;
      rx_data_q <= '0;
      rx_push_q <= 1'b0;
    end else begin
      if (!armed) prime_q <= prime_q + 4'd1;
      sclk_q    <= sclk_lvl_i;
      ss_q      <= ss_lvl_i;
      rx_push_q <= 1'b0;
      if (act_on && !sel_q) sel_q <= 1'b1;
      else if (act_off)     sel_q <= 1'b0;
      if (!sel_q || act_off) begin
        loaded_q  <= 1'b0;
        tx_cnt_q  <= '0;
        rx_cnt_q  <= '0;
        rx_word_q <= '0;
      end else begin
        if (start) begin
          tx_word_q <= tx_valid_i ? tx_data_i : '1;
          loaded_q  <= 1'b1;
          tx_cnt_q  <= '0;
        end else if (shift) begin
          tx_cnt_q  <= tx_cnt_q + CW'(1);
        end
        if (samp) begin
          if (last) begin
            rx_push_q <= 1'b1;
            rx_data_q <= rx_word_q | (MAX_W'(mosi_lvl_i) << rx_idx);
            rx_word_q <= '0;
            rx_cnt_q  <= '0;
            tx_cnt_q  <= '0;
            loaded_q  <= 1'b0;
          end else begin
            rx_word_q[rx_idx] <= mosi_lvl_i;
            rx_cnt_q          <= rx_cnt_q + CW'(1);
          end
        end
      end
    end
  end

  assign tx_pop_o  = start & tx_valid_i;
  assign unf_set_o = start & ~tx_valid_i;
  assign err_set_o = sel_q & act_off & loaded_q;
  assign miso_oe_o = sel_q;
  assign rx_push_o = rx_push_q;
  assign rx_data_o = rx_data_q;

  p_rx_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_q < eff_w);
  p_tx_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |-> (tx_cnt_q < eff_w));
  p_err_deselects_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_o |=> !miso_oe_o);
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core
  import spi_slv_pkg::*;
#(
  parameter int unsigned MAX_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             msb_first_i,
  input  logic [CW-1:0]    width_i,
  input  logic             ss_pol_i,
  input  logic             filter_en_i,
  input  logic             sclk_i,
  input  logic             mosi_i,
  input  logic             ss_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             tx_valid_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [MAX_W-1:0] rx_data_o,
  input  logic             flag_clr_i,
  output logic             underflow_o,
  output logic             slave_err_o
);
  logic [N_LINES-1:0] raw_w, lvl_w;
  logic unf_set, err_set;

  assign raw_w[LN_SCLK] = sclk_i;
  assign raw_w[LN_MOSI] = mosi_i;
  assign raw_w[LN_SS]   = ss_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_in
    spi_slv_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .filter_en_i (filter_en_i),
      .line_i      (raw_w[g]),
      .lvl_o       (lvl_w[g])
    );
  end

  spi_slv_frame #(.MAX_W(MAX_W), .SYNC_STAGES(SYNC_STAGES)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpol_i      (cpol_i),
    .cpha_i      (cpha_i),
    .msb_first_i (msb_first_i),
    .width_i     (width_i),
    .ss_pol_i    (ss_pol_i),
    .sclk_lvl_i  (lvl_w[LN_SCLK]),
    .mosi_lvl_i  (lvl_w[LN_MOSI]),
    .ss_lvl_i    (lvl_w[LN_SS]),
    .tx_valid_i  (tx_valid_i),
    .tx_data_i   (tx_data_i),
    .tx_pop_o    (tx_pop_o),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o),
    .rx_push_o   (rx_push_o),
    .rx_data_o   (rx_data_o),
    .unf_set_o   (unf_set),
    .err_set_o   (err_set)
  );

  spi_slv_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .unf_set_i   (unf_set),
    .err_set_i   (err_set),
    .clr_i       (flag_clr_i),
    .underflow_o (underflow_o),
    .slave_err_o (slave_err_o)
  );

  p_unf_from_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(!tx_valid_i));
  p_pop_push_apart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_pop_o && rx_push_o));
endmodule

// File: tb/spi_slave_core_bench.sv
module spi_slave_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 0, cpha = 0, msb = 1, ss_pol = 0, filt = 0;
  logic [4:0] width = 5'd8;
  logic sclk_i = 0, mosi_i = 0, ss_i = 1;
  logic miso_o, miso_oe_o, tx_pop_o, rx_push_o, underflow_o, slave_err_o;
  logic tx_valid = 0, flag_clr = 0;
  logic [15:0] tx_data = '0, rx_data_o;

  logic [15:0] tx_q [$];
  logic [15:0] exp_rx [$];
  logic [15:0] mw [4];
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_core u_spi_slave_core (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .msb_first_i(msb),
    .width_i(width), .ss_pol_i(ss_pol), .filter_en_i(filt), .sclk_i(sclk_i),
    .mosi_i(mosi_i), .ss_i(ss_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_pop_o(tx_pop_o),
    .rx_push_o(rx_push_o), .rx_data_o(rx_data_o), .flag_clr_i(flag_clr),
    .underflow_o(underflow_o), .slave_err_o(slave_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // first-word-fall-through TX FIFO model
  always @(posedge clk) begin
    if (tx_pop_o && tx_q.size() > 0) tx_q.delete(0);
    tx_valid <= (tx_q.size() != 0);
    tx_data  <= (tx_q.size() != 0) ? tx_q[0] : 16'h0;
  end

  // RX side compared against expected queue on every clock
  always @(negedge clk) begin
    if (rst_n && rx_push_o) begin
      if (exp_rx.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected push act=%0h exp=none", rx_data_o);
      end else begin
        chk("R2 rx data", rx_data_o, exp_rx.pop_front());
      end
    end
  end

  task automatic run_frame(input int n, input int cut, input bit glitch, input string req);
    logic [15:0] snap [$];
    logic [15:0] got, expv, msk;
    int bi;
    snap = tx_q;
    msk = 16'((32'd1 << width) - 1);
    ss_i = ss_pol;
    wait_cyc(H);
    for (int e = 0; e < n; e++) begin
      expv = (e < snap.size()) ? snap[e] : 16'hFFFF;
      if (cut < 0) exp_rx.push_back(mw[e] & msk);
      got = '0;
      for (int b = 0; b < int'(width); b++) begin
        if (cut >= 0 && b == cut) break;
        bi = msb ? int'(width) - 1 - b : b;
        if (!cpha) begin
          mosi_i = mw[e][bi];
          if (glitch) begin
            wait_cyc(3);
            mosi_i = ~mosi_i; sclk_i = ~sclk_i;
            wait_cyc(1);
            mosi_i = ~mosi_i; sclk_i = ~sclk_i;
            wait_cyc(H - 4);
          end else wait_cyc(H);
          got[bi] = miso_o;
          sclk_i = ~cpol;
          wait_cyc(H);
          sclk_i = cpol;
        end else begin
          sclk_i = ~cpol;
          mosi_i = mw[e][bi];
          wait_cyc(H);
          got[bi] = miso_o;
          sclk_i = cpol;
          wait_cyc(H);
        end
      end
      if (cut < 0) chk({req, " miso word"}, got, expv & msk);
    end
    wait_cyc(H);
    ss_i = ~ss_pol;
    wait_cyc(4 * H);
    chk({req, " R2 push count"}, exp_rx.size(), 0);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic m, input int w, input logic sp);
    cpol = p; cpha = h; msb = m; width = 5'(w); ss_pol = sp;
    sclk_i = p; ss_i = ~sp;
    wait_cyc(4 * H);
  endtask

  task automatic pulse_clr();
    flag_clr = 1; wait_cyc(1); flag_clr = 0; wait_cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    // R11 reset state
    chk("R11 miso", miso_o, 1);
    chk("R11 oe", miso_oe_o, 0);
    chk("R11 pop", tx_pop_o, 0);
    chk("R11 push", rx_push_o, 0);
    chk("R11 flags", {underflow_o, slave_err_o}, 0);
    rst_n = 1;
    wait_cyc(20);

    // R1: data loaded and clocks without select start nothing
    tx_q.push_back(16'h00A5); tx_q.push_back(16'h003C);
    for (int i = 0; i < 10; i++) begin
      sclk_i = ~sclk_i; wait_cyc(H);
      chk("R1 oe while unselected", miso_oe_o, 0);
    end
    sclk_i = 0;
    wait_cyc(100);
    chk("R1 fifo untouched", tx_q.size(), 2);

    // R5 R7: mode 0, MSB first, 8 bits, two back-to-back elements
    set_mode(0, 0, 1, 8, 0);
    mw[0] = 16'h0096; mw[1] = 16'h005B;
    run_frame(2, -1, 0, "R5 R7 mode0 msb w8");
    chk("R3 no underflow", underflow_o, 0);

    // mode 1, LSB first, 12 bits
    set_mode(0, 1, 0, 12, 0);
    tx_q.push_back(16'h0A5C); tx_q.push_back(16'h0F03);
    mw[0] = 16'h0123; mw[1] = 16'h0CBA;
    run_frame(2, -1, 0, "R5 R7 mode1 lsb w12");

    // mode 2, MSB first, 4 bits
    set_mode(1, 0, 1, 4, 0);
    tx_q.push_back(16'h0009); tx_q.push_back(16'h0006);
    mw[0] = 16'h0003; mw[1] = 16'h000E;
    run_frame(2, -1, 0, "R5 R6 mode2 msb w4");

    // mode 3, LSB first, 16 bits, select active high
    set_mode(1, 1, 0, 16, 1);
    tx_q.push_back(16'hC3A1);
    mw[0] = 16'h5E17;
    run_frame(1, -1, 0, "R8 R6 mode3 lsb w16 ss high");
    chk("R4 no error", slave_err_o, 0);

    // R6: width 6 with upper bits set on both sides
    set_mode(0, 0, 1, 6, 0);
    tx_q.push_back(16'hFFE9);
    mw[0] = 16'hFFC5;
    run_frame(1, -1, 0, "R6 w6 masking");

    // R3: empty FIFO gives ones and a sticky flag, RX still pushed
    mw[0] = 16'h0042;
    set_mode(0, 0, 1, 8, 0);
    run_frame(1, -1, 0, "R3 underflow");
    chk("R3 underflow set", underflow_o, 1);
    tx_q.push_back(16'h0071);
    mw[0] = 16'h0018;
    run_frame(1, -1, 0, "R10 following frame");
    chk("R10 underflow held", underflow_o, 1);
    pulse_clr();
    chk("R10 underflow cleared", underflow_o, 0);

    // R4: deselect after three bits, partial element dropped
    set_mode(0, 1, 1, 8, 0);
    tx_q.push_back(16'h00E7);
    mw[0] = 16'h00FF;
    run_frame(1, 3, 0, "R4 cut");
    chk("R4 error set", slave_err_o, 1);
    chk("R4 element was popped", tx_q.size(), 0);
    pulse_clr();
    chk("R10 error cleared", slave_err_o, 0);

    // R9: filter removes single-cycle glitches on SCLK and MOSI
    filt = 1;
    set_mode(0, 0, 1, 8, 0);
    tx_q.push_back(16'h00C9); tx_q.push_back(16'h0035);
    mw[0] = 16'h0066; mw[1] = 16'h0099;
    run_frame(2, -1, 1, "R9 filtered glitches");
    chk("R9 no error", {underflow_o, slave_err_o}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule